// File: doc/BRIEF.md
# Memory Transfer Sequencer

This block sits between a processor core and a simple memory port. It moves every transfer through two private registers, an address holder and a data holder, in a fixed sequence of steps. The core raises a request with a direction bit, an address and, for a store, a data word. The block then loads its registers one step per clock and raises a memory strobe. It waits for the memory's ready input, and finally returns a one-cycle completion pulse to the core.

For a store, the data holder is loaded first, then the address holder, and only then is the write strobe raised. For a load, the address holder is loaded, then the read strobe is raised. The word from memory is captured into the data holder on the ready cycle. The core's read bus is fed only from the data holder. The memory address and write-data buses are fed only from the two holders, so neither bus ever shows a live core input. Neither holder can be reached by the core other than through a transfer.

The core must keep its address and write data steady until the load steps have taken them. While a transfer is under way, a busy output is high and any new request is disregarded.

Top module: `mem_xfer_seq`

## Requirements
- R1: After reset, cpu_busy, cpu_done, mem_rd and mem_wr are low, and mem_addr, mem_wdata and cpu_rdata are zero.
- R2: A request accepted with cpu_we=1 (store) loads the data holder from cpu_wdata one clock after acceptance. The address holder is loaded from cpu_addr one clock later, and mem_wr goes high in that same cycle, never earlier.
- R3: A request accepted with cpu_we=0 (load) loads the address holder from cpu_addr one clock after acceptance, and mem_rd goes high in that same cycle.
- R4: A strobe that is high stays high while mem_ready is low, and it drops in the cycle after mem_ready is seen high.
- R5: On a load, the data holder captures mem_rdata on the clock where mem_rd and mem_ready are both high. cpu_rdata shows that word from the next cycle on, and it changes at no other time except a store's data load.
- R6: cpu_done is high for exactly one cycle: the cycle after the strobe phase ends.
- R7: cpu_busy is high from the cycle after acceptance through the done cycle. cpu_req, cpu_we, cpu_addr and cpu_wdata are ignored while cpu_busy is high, and mem_ready is ignored while no strobe is high.
- R8: mem_addr changes only at an address-load step, and mem_wdata changes only at a data-load step.
- R9: mem_rd and mem_wr are never high together, and neither is high unless cpu_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Transfer request, sampled while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Transfer address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Data holder contents |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Transfer in progress |
| mem_addr | output | ADDR_W | Address holder contents |
| mem_wdata | output | DATA_W | Data holder contents |
| mem_rdata | input | DATA_W | Word from memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_ready | input | 1 | Memory ready |

## Verification
Directed stores and loads are run with ready latencies of zero, two, three and five cycles. This separates the fixed load steps from the open-ended strobe wait, and a store followed by a load of the same address shows that the captured word reaches cpu_rdata. Some transfers have a request raised with changed operands during the strobe phase. These show that busy-time inputs touch neither holder nor start a second transfer. A long pseudo-random phase then toggles requests, direction, operands and ready on every cycle, including ready pulses while idle. A behavioural model is compared against every output on every clock, which catches misordered load steps, late or early strobes and stray captures.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_W_DAT = 3'd1,
      ST_W_ADR = 3'd2,
      ST_W_STB = 3'd3,
      ST_R_ADR = 3'd4,
      ST_R_STB = 3'd5,
      ST_FIN   = 3'd6
   } mxs_state_e;

   typedef struct packed {
      logic ld_adr;
      logic ld_dat;
      logic dat_from_mem;
      logic rd;
      logic wr;
      logic busy;
      logic fin;
   } mxs_ctl_t;

endpackage

// File: rtl/mxs_reg.sv
module mxs_reg #(
   parameter int          W         = 8,
   parameter bit          RST_ASYNC = 1'b1,
   parameter logic [W-1:0] RST_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("mxs_reg: W must be at least 1");
   end

   if (RST_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= RST_VAL;
         else if (ld) q <= d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n)  q <= RST_VAL;
         else if (ld) q <= d;
      end
   end

endmodule

// File: rtl/mxs_ctrl.sv
module mxs_ctrl
   import mxs_pkg::*;
#(
   parameter bit RST_ASYNC = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req,
   input  logic     we,
   input  logic     ready,
   output mxs_ctl_t ctl
);

   mxs_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req) state_d = we ? ST_W_DAT : ST_R_ADR;
         ST_W_DAT: state_d = ST_W_ADR;
         ST_W_ADR: state_d = ST_W_STB;
         ST_W_STB: if (ready) state_d = ST_FIN;
         ST_R_ADR: state_d = ST_R_STB;
         ST_R_STB: if (ready) state_d = ST_FIN;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   if (RST_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) state_q <= ST_IDLE;
         else        state_q <= state_d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) state_q <= ST_IDLE;
         else        state_q <= state_d;
      end
   end

   always_comb begin
      ctl              = '0;
      ctl.busy         = (state_q != ST_IDLE);
      ctl.fin          = (state_q == ST_FIN);
      ctl.wr           = (state_q == ST_W_STB);
      ctl.rd           = (state_q == ST_R_STB);
      ctl.ld_adr       = (state_q == ST_W_ADR) || (state_q == ST_R_ADR);
      ctl.dat_from_mem = (state_q == ST_R_STB);
      ctl.ld_dat       = (state_q == ST_W_DAT) || ((state_q == ST_R_STB) && ready);
   end

endmodule

// File: rtl/mem_xfer_seq.sv
module mem_xfer_seq
   import mxs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter bit RST_ASYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              cpu_busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic              mem_ready
);

   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_aw
      $error("mem_xfer_seq: ADDR_W out of range 1..64");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_dw
      $error("mem_xfer_seq: DATA_W out of range 1..64");
   end

   mxs_ctl_t          ctl;
   logic [ADDR_W-1:0] adr_q;
   logic [DATA_W-1:0] dat_q;
   logic [DATA_W-1:0] dat_d;

   mxs_ctrl #(.RST_ASYNC(RST_ASYNC)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cpu_req),
      .we    (cpu_we),
      .ready (mem_ready),
      .ctl   (ctl)
   );

   assign dat_d = ctl.dat_from_mem ? mem_rdata : cpu_wdata;

   mxs_reg #(.W(ADDR_W), .RST_ASYNC(RST_ASYNC)) u_adr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ctl.ld_adr),
      .d     (cpu_addr),
      .q     (adr_q)
   );

   mxs_reg #(.W(DATA_W), .RST_ASYNC(RST_ASYNC)) u_dat (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ctl.ld_dat),
      .d     (dat_d),
      .q     (dat_q)
   );

   assign mem_addr  = adr_q;
   assign mem_wdata = dat_q;
   assign cpu_rdata = dat_q;
   assign mem_rd    = ctl.rd;
   assign mem_wr    = ctl.wr;
   assign cpu_busy  = ctl.busy;
   assign cpu_done  = ctl.fin;

endmodule

// File: rtl/mem_xfer_seq_chk.sv
module mem_xfer_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              cpu_done,
   input logic              cpu_busy,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_ready
);

   // R9
   p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> cpu_busy);

   // R4
   p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ready) |=> mem_wr);
   p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> mem_rd);
   p_strobe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && mem_ready) |=> !(mem_rd || mem_wr));

   // R6
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);
   p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> ($past(mem_ready) && $past(mem_rd || mem_wr)));

   // R5
   p_rdata_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_ready) |=> (cpu_rdata == $past(mem_rdata)));

   // R2
   p_wr_after_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |-> ($past(cpu_busy, 1) && $past(cpu_busy, 2)));

   // R3
   p_rd_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |-> ($past(cpu_busy, 1) && !$past(cpu_busy, 2)));

   // R8
   p_addr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |=> $stable(mem_addr));
   p_addr_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |=> $stable(mem_addr));
   p_wdata_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> $stable(mem_wdata));

   // R7
   p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_busy);

endmodule

bind mem_xfer_seq mem_xfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mem_xfer_seq_tb.sv
`timescale 1ns/1ps
module mem_xfer_seq_tb;

   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_req, cpu_we;
   logic [AW-1:0] cpu_addr;
   logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
   logic          cpu_done, cpu_busy, mem_rd, mem_wr, mem_ready;
   logic [AW-1:0] mem_addr;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [DW-1:0] mem_model [logic [AW-1:0]];

   // behavioural reference state
   int            m_phase = 0;
   logic [AW-1:0] m_adr = '0;
   logic [DW-1:0] m_dat = '0;

   always #4 clk = ~clk;

   mem_xfer_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_done(cpu_done), .cpu_busy(cpu_busy), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_ready(mem_ready)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock model comparison at the falling edge
   always @(negedge clk) begin
      if (!finished) begin
         check("R7 busy",      cpu_busy,  m_phase != 0);
         check("R6 done",      cpu_done,  m_phase == 6);
         check("R4 mem_wr",    mem_wr,    m_phase == 3);
         check("R4 mem_rd",    mem_rd,    m_phase == 5);
         check("R8 mem_addr",  mem_addr,  m_adr);
         check("R8 mem_wdata", mem_wdata, m_dat);
         check("R5 cpu_rdata", cpu_rdata, m_dat);
         check("R9 strobes",   mem_rd & mem_wr, 1'b0);
      end
      if (!rst_n) begin
         m_phase = 0; m_adr = '0; m_dat = '0;
      end else begin
         case (m_phase)
            0: if (cpu_req) m_phase = cpu_we ? 1 : 4;
            1: begin m_dat = cpu_wdata; m_phase = 2; end
            2: begin m_adr = cpu_addr;  m_phase = 3; end
            3: if (mem_ready) m_phase = 6;
            4: begin m_adr = cpu_addr;  m_phase = 5; end
            5: if (mem_ready) begin m_dat = mem_rdata; m_phase = 6; end
            default: m_phase = 0;
         endcase
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic run_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int lat, input bit noisy);
      logic [DW-1:0] rword;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      step();                                   // accepted at this edge
      cpu_req = 1'b0;
      check("R7 busy after accept", cpu_busy, 1'b1);
      check("R9 no strobe at accept", mem_rd | mem_wr, 1'b0);
      step();
      if (we) begin
         check("R2 data loaded first", mem_wdata, d);
         check("R2 no write strobe yet", mem_wr, 1'b0);
         step();
         check("R2 address loaded second", mem_addr, a);
         check("R2 write strobe after loads", mem_wr, 1'b1);
      end else begin
         check("R3 address loaded", mem_addr, a);
         check("R3 read strobe", mem_rd, 1'b1);
      end
      if (noisy) begin
         cpu_req = 1'b1; cpu_we = ~we; cpu_addr = ~a; cpu_wdata = ~d;
      end
      for (int i = 0; i < lat; i++) begin
         step();
         check("R4 strobe held", we ? mem_wr : mem_rd, 1'b1);
         check("R7 address unchanged while busy", mem_addr, a);
      end
      cpu_req = 1'b0;
      rword = mem_model.exists(a) ? mem_model[a] : {a, ~a};
      if (we) mem_model[a] = d;
      mem_rdata = rword; mem_ready = 1'b1;
      step();
      mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      check("R6 done after strobe", cpu_done, 1'b1);
      check("R4 strobe dropped", mem_rd | mem_wr, 1'b0);
      if (!we) check("R5 read word in holder", cpu_rdata, rword);
      else     check("R8 store word kept", mem_wdata, d);
      step();
      check("R6 done single cycle", cpu_done, 1'b0);
      check("R7 idle after done", cpu_busy, 1'b0);
      step();
      check("R7 no transfer from ignored request", cpu_busy, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
      mem_rdata = '0; mem_ready = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 busy", cpu_busy, 1'b0);
      check("R1 done", cpu_done, 1'b0);
      check("R1 strobes", {mem_rd, mem_wr}, 2'b00);
      check("R1 mem_addr", mem_addr, '0);
      check("R1 data", {mem_wdata, cpu_rdata}, '0);
      rst_n = 1'b1;
      step();
      // ready while idle must be ignored
      mem_ready = 1'b1; mem_rdata = 32'h1111_2222;
      step();
      mem_ready = 1'b0;
      check("R7 ready ignored while idle", {cpu_busy, cpu_rdata}, 33'h0);
      run_op(1'b1, 16'h1234, 32'hA5A5_0001, 0, 1'b0);
      run_op(1'b1, 16'h00F0, 32'h5A5A_0002, 3, 1'b0);
      run_op(1'b0, 16'h1234, 32'h0,         0, 1'b0);
      run_op(1'b0, 16'h00F0, 32'h0,         5, 1'b1);
      run_op(1'b1, 16'hFFFF, 32'hFFFF_FFFF, 2, 1'b1);
      run_op(1'b0, 16'h0BAD, 32'h0,         2, 1'b1);
      for (int c = 0; c < 4000; c++) begin
         cpu_req   = ($urandom % 4) == 0;
         cpu_we    = $urandom % 2;
         cpu_addr  = AW'($urandom);
         cpu_wdata = $urandom;
         mem_ready = ($urandom % 3) == 0;
         mem_rdata = $urandom;
         step();
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule